// File: doc/BRIEF.md
# Pixel Color Component Extractor

This block sits in a display pipeline between the pixel fetch stage and the video output. Each clock it takes one raw framebuffer word plus two flags: whether a pixel is actually present, and whether the current position lies inside the visible area. It returns one 8-bit red, green and blue value per clock.

A format register sets how many bytes make up one pixel. Bytes above that count are treated as zero. Each color channel has its own select register with three fields: the position of the lowest bit to take, the number of bits to take, and a fallback color value. The block takes the field out of the pixel and widens it to 8 bits by repeating its bit pattern downward.

The fallback value replaces the channel output in three cases: when the position is outside the visible area, when the source has no pixel for a visible position (an underrun), or when the channel's bit count is zero. Setting the red fallback to 0xFF makes underruns visible as red. The result is registered, so every output is valid exactly one clock after its inputs.

Top module: `ppx_extract`

## Requirements
- R1: While reset is asserted, and after it is released until the first clock edge, all three color outputs and the visible output are zero.
- R2: Each output reflects the inputs sampled at the previous rising clock edge; `vis_o` equals the `pix_visible` value of that edge.
- R3: Bits [4:3] of `fmt_reg` hold the pixel size in bytes minus one (0 = 1 byte, 3 = 4 bytes). Bytes of `pix_word` at or above that size read as zero.
- R4: In each select register, bits [4:0] are the lowest bit index of the field, bits [11:8] are the field length, and bits [23:16] are the fallback value. A field of length 8 at index L yields pixel bits [L+7:L] unchanged.
- R5: A field of N bits with 1 ≤ N < 8 is placed in the top N output bits, and its pattern is repeated into the lower bits. For example, 3 bits abc give abcabcab, and a 1-bit field gives 0x00 or 0xFF.
- R6: A length field above 8 is treated as 8.
- R7: A channel whose length field is zero outputs its fallback value; the other channels are not affected.
- R8: When `pix_visible` is 0, every channel outputs its fallback value, whatever `pix_valid` and `pix_word` are.
- R9: When `pix_visible` is 1 and `pix_valid` is 0 (underrun), every channel outputs its fallback value.
- R10: Field bits that lie above pixel bit 31 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_reg | input | 32 | Format register; bits [4:3] = bytes per pixel minus one |
| sel_red | input | 32 | Red select: [23:16] fallback, [11:8] length, [4:0] lowest bit |
| sel_grn | input | 32 | Green select, same layout |
| sel_blu | input | 32 | Blue select, same layout |
| pix_word | input | 32 | Raw framebuffer word, byte 0 in bits [7:0] |
| pix_valid | input | 1 | A pixel is present in `pix_word` |
| pix_visible | input | 1 | Current position is inside the visible area |
| red_o | output | 8 | Registered red component |
| grn_o | output | 8 | Registered green component |
| blu_o | output | 8 | Registered blue component |
| vis_o | output | 1 | `pix_visible` delayed by one clock |

## Verification
The bench targets field widths that do not divide 8, such as 5- and 6-bit fields. A design that only shifts left instead of repeating the pattern would leave the low bits zero there, and a 1-bit field would not reach 0xFF. It sets the pixel size to one or two bytes while upper word bytes are nonzero, and places a field at the top of the word. A design that skips the byte mask, or wraps the shift, would then pull stray bits into the output. Length values of 0 and above 8 are covered, along with blanking and underrun while a nonzero pixel is present, so that a swapped or missing fallback path shows up as raw data on the output. A back-to-back stream changes the inputs every clock, which exposes a latency other than one clock.

// File: rtl/ppx_pkg.sv
`timescale 1ns/1ps
package ppx_pkg;
  localparam int REG_W  = 32;
  localparam int DFLT_W = 8;
  localparam int LEN_W  = 4;
  localparam int LSB_W  = 5;

  typedef struct packed {
    logic [DFLT_W-1:0] dflt;
    logic [LEN_W-1:0]  len;
    logic [LSB_W-1:0]  lsb;
  } chan_sel_t;

  // Field positions are fixed by the register layout software writes.
  function automatic chan_sel_t decode_sel(input logic [REG_W-1:0] r);
    chan_sel_t s;
    s.dflt = r[23:16];
    s.len  = r[11:8];
    s.lsb  = r[4:0];
    return s;
  endfunction

  function automatic logic [1:0] decode_bpp_m1(input logic [REG_W-1:0] f);
    return f[4:3];
  endfunction
endpackage

// File: rtl/ppx_byte_mask.sv
`timescale 1ns/1ps
module ppx_byte_mask #(
  parameter int PIX_BYTES = 4,
  localparam int PIX_W = PIX_BYTES * 8,
  localparam int BPP_W = (PIX_BYTES > 1) ? $clog2(PIX_BYTES) : 1
) (
  input  logic [PIX_W-1:0] raw_word,
  input  logic [BPP_W-1:0] bpp_m1,
  output logic [PIX_W-1:0] pix_word
);
  logic [PIX_BYTES-1:0] keep_byte;

  for (genvar b = 0; b < PIX_BYTES; b++) begin : g_byte
    localparam logic [BPP_W:0] BIDX = (BPP_W+1)'(b);
    assign keep_byte[b] = (BIDX <= {1'b0, bpp_m1});
    assign pix_word[b*8 +: 8] = keep_byte[b] ? raw_word[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/ppx_chan.sv
`timescale 1ns/1ps
module ppx_chan
  import ppx_pkg::*;
#(
  parameter int PIX_W = 32,
  parameter int OUT_W = 8,
  localparam int IDX_W = $clog2(OUT_W)
) (
  input  logic [PIX_W-1:0] pix_word,
  input  chan_sel_t        sel,
  input  logic             force_dflt,
  output logic [OUT_W-1:0] comp,
  output logic             zero_len
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(OUT_W);

  // Mask of the low n bits.
  function automatic logic [OUT_W-1:0] low_mask(input logic [LEN_W-1:0] n);
    logic [OUT_W-1:0] m;
    for (int i = 0; i < OUT_W; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  // Left-align an n-bit field and repeat its pattern into the low bits.
  function automatic logic [OUT_W-1:0] widen(input logic [OUT_W-1:0] f,
                                             input logic [LEN_W-1:0] n);
    logic [OUT_W-1:0] r;
    int nn;
    int k;
    r  = '0;
    nn = int'(n);
    if (nn != 0) begin
      for (int i = 0; i < OUT_W; i++) begin
        k = nn - 1 - (i % nn);
        r[OUT_W-1-i] = f[k[IDX_W-1:0]];
      end
    end
    return r;
  endfunction

  logic [LEN_W-1:0] len_eff;
  logic [OUT_W-1:0] field_raw;
  logic [OUT_W-1:0] field;
  logic [OUT_W-1:0] widened;

  assign zero_len  = (sel.len == '0);
  assign len_eff   = (sel.len > LEN_MAX) ? LEN_MAX : sel.len;
  assign field_raw = OUT_W'(pix_word >> sel.lsb);
  assign field     = field_raw & low_mask(len_eff);
  assign widened   = widen(field, len_eff);
  assign comp      = (force_dflt || zero_len) ? sel.dflt : widened;
endmodule

// File: rtl/ppx_extract.sv
`timescale 1ns/1ps
module ppx_extract
  import ppx_pkg::*;
#(
  parameter int PIX_BYTES = 4,
  parameter int OUT_W     = 8,
  localparam int PIX_W    = PIX_BYTES * 8,
  localparam int BPP_W    = (PIX_BYTES > 1) ? $clog2(PIX_BYTES) : 1,
  localparam int NUM_CH   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      fmt_reg,
  input  logic [31:0]      sel_red,
  input  logic [31:0]      sel_grn,
  input  logic [31:0]      sel_blu,
  input  logic [PIX_W-1:0] pix_word,
  input  logic             pix_valid,
  input  logic             pix_visible,
  output logic [OUT_W-1:0] red_o,
  output logic [OUT_W-1:0] grn_o,
  output logic [OUT_W-1:0] blu_o,
  output logic             vis_o
);
  // Named events for the fallback paths.
  logic blank_ev;
  logic underrun_ev;
  logic use_dflt;
  assign blank_ev    = !pix_visible;
  assign underrun_ev = pix_visible && !pix_valid;
  assign use_dflt    = blank_ev || underrun_ev;

  logic [1:0]       bpp_raw;
  logic [BPP_W-1:0] bpp_m1;
  logic [PIX_W-1:0] pix_packed;
  assign bpp_raw = decode_bpp_m1(fmt_reg);
  assign bpp_m1  = BPP_W'(bpp_raw);

  ppx_byte_mask #(.PIX_BYTES(PIX_BYTES)) u_mask (
    .raw_word (pix_word),
    .bpp_m1   (bpp_m1),
    .pix_word (pix_packed)
  );

  chan_sel_t        sel_arr  [NUM_CH];
  logic [OUT_W-1:0] comp_arr [NUM_CH];
  logic [OUT_W-1:0] comp_q   [NUM_CH];
  logic [NUM_CH-1:0] zero_len_ev;

  assign sel_arr[0] = decode_sel(sel_red);
  assign sel_arr[1] = decode_sel(sel_grn);
  assign sel_arr[2] = decode_sel(sel_blu);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    ppx_chan #(.PIX_W(PIX_W), .OUT_W(OUT_W)) u_chan (
      .pix_word   (pix_packed),
      .sel        (sel_arr[c]),
      .force_dflt (use_dflt),
      .comp       (comp_arr[c]),
      .zero_len   (zero_len_ev[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) comp_q[c] <= '0;
      else        comp_q[c] <= comp_arr[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vis_o <= 1'b0;
    else        vis_o <= pix_visible;
  end

  assign red_o = comp_q[0];
  assign grn_o = comp_q[1];
  assign blu_o = comp_q[2];

  // R2: visible flag delayed by exactly one clock
  a_r2_vis_latency: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (vis_o == $past(pix_visible)));

  // R8: blanking puts every fallback on the outputs
  a_r8_blank_dflt: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_visible |=> (red_o == $past(sel_red[23:16]) &&
                      grn_o == $past(sel_grn[23:16]) &&
                      blu_o == $past(sel_blu[23:16])));

  // R9: underrun puts every fallback on the outputs
  a_r9_underrun_dflt: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_visible && !pix_valid) |=> (red_o == $past(sel_red[23:16]) &&
                                     grn_o == $past(sel_grn[23:16]) &&
                                     blu_o == $past(sel_blu[23:16])));

  // R7: zero-length red field gives the red fallback
  a_r7_zero_len_red: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_red[11:8] == 4'h0) |=> (red_o == $past(sel_red[23:16])));

  // R5: a one-bit green field widens to all zeros or all ones
  a_r5_one_bit_green: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_visible && pix_valid && sel_grn[11:8] == 4'h1)
      |=> (grn_o == '0 || grn_o == '1));

  // R4: an 8-bit blue field at bit 0 of a visible pixel passes byte 0 through
  a_r4_blue_byte0: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_visible && pix_valid && sel_blu[11:8] == 4'h8 && sel_blu[4:0] == 5'd0)
      |=> (blu_o == $past(pix_word[7:0])));
endmodule

// File: tb/ppx_extract_tb.sv
`timescale 1ns/1ps
module ppx_extract_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fmt_reg = '0;
  logic [31:0] sel_red = '0, sel_grn = '0, sel_blu = '0;
  logic [31:0] pix_word = '0;
  logic        pix_valid = 1'b0, pix_visible = 1'b0;
  logic [7:0]  red_o, grn_o, blu_o;
  logic        vis_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  ppx_extract dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_reg(fmt_reg),
    .sel_red(sel_red), .sel_grn(sel_grn), .sel_blu(sel_blu),
    .pix_word(pix_word), .pix_valid(pix_valid), .pix_visible(pix_visible),
    .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o), .vis_o(vis_o)
  );

  function automatic logic [31:0] mk_sel(input logic [7:0] dflt,
                                         input logic [3:0] len,
                                         input logic [4:0] lsb);
    return {8'h00, dflt, 4'h0, len, 3'b000, lsb};
  endfunction

  function automatic logic [31:0] mk_fmt(input int bytes);
    logic [1:0] m;
    m = 2'(bytes - 1);
    return {27'd0, m, 3'b000};
  endfunction

  // Reference model, written from the requirements.
  function automatic logic [7:0] model(input logic [31:0] fmt, input logic [31:0] sel,
                                       input logic [31:0] word, input logic val,
                                       input logic vis);
    longint unsigned pix, fld, acc;
    int nb, len, bits;
    nb  = int'(fmt[4:3]) + 1;
    pix = longint'(word) & ((64'd1 << (8*nb)) - 1);
    len = int'(sel[11:8]);
    if (!vis || !val || len == 0) return sel[23:16];
    if (len > 8) len = 8;
    fld = (pix >> sel[4:0]) & ((64'd1 << len) - 1);
    acc = 0; bits = 0;
    while (bits < 8) begin
      acc = (acc << len) | fld;
      bits += len;
    end
    return 8'(acc >> (bits - 8));
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  // Apply one pixel at a falling edge, check it one clock later.
  task automatic drive_check(input string tag, input logic [31:0] word,
                             input logic val, input logic vis);
    @(negedge clk);
    pix_word = word; pix_valid = val; pix_visible = vis;
    @(negedge clk);
    chk({tag, " red"}, 32'(red_o), 32'(model(fmt_reg, sel_red, word, val, vis)));
    chk({tag, " grn"}, 32'(grn_o), 32'(model(fmt_reg, sel_grn, word, val, vis)));
    chk({tag, " blu"}, 32'(blu_o), 32'(model(fmt_reg, sel_blu, word, val, vis)));
    chk({tag, " vis"}, 32'(vis_o), 32'(vis));
  endtask

  task automatic t_reset();
    pix_word = 32'hFFFF_FFFF; pix_valid = 1'b1; pix_visible = 1'b1;
    sel_red = mk_sel(8'hAA, 4'd8, 5'd0);
    #1;
    chk("R1 red in reset", 32'(red_o), 32'h0);
    chk("R1 grn in reset", 32'(grn_o), 32'h0);
    chk("R1 blu in reset", 32'(blu_o), 32'h0);
    chk("R1 vis in reset", 32'(vis_o), 32'h0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk("R1 red after release", 32'(red_o), 32'h0);
  endtask

  task automatic t_rgb888();
    fmt_reg = mk_fmt(4);
    sel_red = mk_sel(8'h00, 4'd8, 5'd16);
    sel_grn = mk_sel(8'h00, 4'd8, 5'd8);
    sel_blu = mk_sel(8'h00, 4'd8, 5'd0);
    drive_check("R4 rgb888 a", 32'h00A1_B2C3, 1'b1, 1'b1);
    chk("R4 red byte2", 32'(red_o), 32'hA1);
    drive_check("R4 rgb888 b", 32'h5F3C_0E81, 1'b1, 1'b1);
  endtask

  task automatic t_rgb565();
    fmt_reg = mk_fmt(2);
    sel_red = mk_sel(8'h00, 4'd5, 5'd11);
    sel_grn = mk_sel(8'h00, 4'd6, 5'd5);
    sel_blu = mk_sel(8'h00, 4'd5, 5'd0);
    drive_check("R5 rgb565 a", 32'h1234_ABCD, 1'b1, 1'b1);
    drive_check("R5 rgb565 white", 32'h0000_FFFF, 1'b1, 1'b1);
    chk("R5 white red", 32'(red_o), 32'hFF);
    // 5-bit 10001 -> 10001100
    drive_check("R5 rgb565 pattern", 32'h0000_8811, 1'b1, 1'b1);
    chk("R5 red 10001 widened", 32'(red_o), 32'h8C);
    chk("R5 blu 10001 widened", 32'(blu_o), 32'h8C);
    sel_red = mk_sel(8'h00, 4'd3, 5'd0);
    sel_grn = mk_sel(8'h00, 4'd1, 5'd2);
    drive_check("R5 3bit and 1bit", 32'h0000_0005, 1'b1, 1'b1);
    chk("R5 3bit 101", 32'(red_o), 32'hB6);
    chk("R5 1bit set", 32'(grn_o), 32'hFF);
  endtask

  task automatic t_byte_mask();
    fmt_reg = mk_fmt(1);
    sel_red = mk_sel(8'h00, 4'd8, 5'd8);
    sel_grn = mk_sel(8'h00, 4'd8, 5'd0);
    sel_blu = mk_sel(8'h00, 4'd4, 5'd6);
    drive_check("R3 one byte", 32'hFFFF_FF3C, 1'b1, 1'b1);
    chk("R3 byte1 masked", 32'(red_o), 32'h00);
    fmt_reg = mk_fmt(3);
    sel_red = mk_sel(8'h00, 4'd8, 5'd24);
    drive_check("R3 three bytes", 32'hEE12_3456, 1'b1, 1'b1);
    chk("R3 byte3 masked", 32'(red_o), 32'h00);
  endtask

  task automatic t_clip_and_top();
    fmt_reg = mk_fmt(4);
    sel_red = mk_sel(8'h00, 4'd12, 5'd4);
    sel_grn = mk_sel(8'h00, 4'd15, 5'd0);
    sel_blu = mk_sel(8'h00, 4'd8, 5'd28);
    drive_check("R6 clip", 32'hF00F_ED5A, 1'b1, 1'b1);
    chk("R6 len12 as 8", 32'(red_o), 32'hD5);
    chk("R10 top bits zero", 32'(blu_o), 32'h0F);
  endtask

  task automatic t_zero_len();
    fmt_reg = mk_fmt(4);
    sel_red = mk_sel(8'h5A, 4'd0, 5'd0);
    sel_grn = mk_sel(8'h33, 4'd8, 5'd8);
    sel_blu = mk_sel(8'hC0, 4'd8, 5'd0);
    drive_check("R7 zero len", 32'h0077_8899, 1'b1, 1'b1);
    chk("R7 red fallback", 32'(red_o), 32'h5A);
    chk("R7 grn unaffected", 32'(grn_o), 32'h88);
  endtask

  task automatic t_blank_underrun();
    fmt_reg = mk_fmt(4);
    sel_red = mk_sel(8'hFF, 4'd8, 5'd16);
    sel_grn = mk_sel(8'h11, 4'd8, 5'd8);
    sel_blu = mk_sel(8'h22, 4'd8, 5'd0);
    drive_check("R8 blank valid", 32'h00AB_CDEF, 1'b1, 1'b0);
    chk("R8 red fallback", 32'(red_o), 32'hFF);
    drive_check("R8 blank invalid", 32'h0012_3456, 1'b0, 1'b0);
    drive_check("R9 underrun", 32'h0012_3456, 1'b0, 1'b1);
    chk("R9 red shows underrun", 32'(red_o), 32'hFF);
    chk("R9 grn fallback", 32'(grn_o), 32'h11);
    drive_check("R9 recover", 32'h0012_3456, 1'b1, 1'b1);
    chk("R9 recover red", 32'(red_o), 32'h12);
  endtask

  task automatic t_stream();
    logic [31:0] w_prev;
    logic        v_prev, s_prev;
    fmt_reg = mk_fmt(4);
    sel_red = mk_sel(8'h40, 4'd8, 5'd16);
    sel_grn = mk_sel(8'h50, 4'd6, 5'd9);
    sel_blu = mk_sel(8'h60, 4'd7, 5'd1);
    w_prev = '0; v_prev = 1'b0; s_prev = 1'b0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R2 stream red", 32'(red_o), 32'(model(fmt_reg, sel_red, w_prev, v_prev, s_prev)));
        chk("R2 stream blu", 32'(blu_o), 32'(model(fmt_reg, sel_blu, w_prev, v_prev, s_prev)));
        chk("R2 stream vis", 32'(vis_o), 32'(s_prev));
      end
      w_prev = 32'h9E37_79B9 * (i + 1);
      v_prev = (i % 5) != 3;
      s_prev = (i % 7) != 6;
      pix_word = w_prev; pix_valid = v_prev; pix_visible = s_prev;
    end
  endtask

  initial begin
    #(200_000 * 5);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_rgb888();
    t_rgb565();
    t_byte_mask();
    t_clip_and_top();
    t_zero_len();
    t_blank_underrun();
    t_stream();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule